// File: doc/BRIEF.md
# Parallel ADC Conversion Read Controller

This block is the host-side sequencer for a 12-bit successive-approximation converter that has a parallel data bus. It drives the active-low conversion-start line. It then waits for the converter's active-low end-of-conversion strobe, which passes through a synchronizer first. Next it holds chip select and read low long enough to cover the data access time, captures the word, and releases the bus. Before it allows the next start it waits out a minimum recovery time. Every analogue timing minimum is a parameter counted in whole periods of the system clock. A user rounds each nanosecond figure up to the next whole period.

A conversion can begin in two ways. The first is a one-cycle request from the host. The second is an internal pacer that restarts conversions at a programmable sample period. The pacer never lets the period fall below the sum of the start, conversion, read and recovery times. Each captured word appears together with a one-cycle valid pulse. A format input can flip the most significant bit, which turns a straight-binary code into a two's-complement value. If the strobe never arrives, a timeout raises a one-cycle error and the controller goes back to idle. The host can also request standby. On release, the controller blocks any new start until the wake-up lockout has passed.

Top module: `adc_par_rdctl`

## Requirements
- R1: During and just after reset, adc_convst_n, adc_cs_n, adc_rd_n and adc_standby_n are all high. sample_valid and eoc_timeout are low, and sample_word is zero.
- R2: When start_req is high in an idle cycle, adc_convst_n goes low in the next cycle and stays low for exactly CONVST_CYC cycles.
- R3: adc_cs_n and adc_rd_n fall together only after the synchronized adc_eoc_n has been seen low, after SYNC_STAGES flops. They then stay low for max(RD_CYC, ACCESS_CYC+1) cycles.
- R4: The bus is captured in the last read cycle. sample_valid is high for one cycle, in the cycle after adc_rd_n rises, and sample_word then holds the captured word until the next capture.
- R5: With fmt_signed=1 at capture, bit DATA_W-1 of the word is inverted and the other bits pass unchanged (0x800 gives 0x000, 0x7FF gives 0xFFF). With fmt_signed=0 the word passes unchanged.
- R6: After adc_rd_n rises, adc_convst_n does not fall for at least RECOV_CYC+1 cycles. If a start is already pending, it falls exactly RECOV_CYC+1 cycles after the rise.
- R7: If the strobe is not seen within EOC_TMO_CYC cycles after the start pulse ends, eoc_timeout is high for one cycle. No read is issued and the controller returns to idle.
- R8: start_req is ignored while a conversion is in progress. A request made during a conversion produces no extra start pulse.
- R9: While standby_req is high in idle, adc_standby_n is low and no start is issued. After release, the first start falls no sooner than WAKE_CYC+1 cycles after adc_standby_n rises. Standby has priority over any start in the same idle cycle.
- R10: With free_run_en=1, successive start pulses are spaced exactly max(sample_period, CONVST_CYC+CONV_CYC+RD_CYC+RECOV_CYC+1) cycles apart, provided each conversion has finished by then.
- R11: A standby request raised during a conversion lets that conversion complete and deliver its word. The controller then enters standby and starts nothing more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_req | input | 1 | Request one conversion (taken in idle) |
| free_run_en | input | 1 | Enable periodic conversions |
| sample_period | input | PERIOD_W | Free-run period in cycles (clamped to the minimum) |
| standby_req | input | 1 | Request converter standby |
| fmt_signed | input | 1 | 1 = invert MSB of captured word |
| adc_eoc_n | input | 1 | End-of-conversion strobe from converter, active low |
| adc_data | input | DATA_W | Converter parallel data bus |
| adc_convst_n | output | 1 | Conversion start, active low |
| adc_cs_n | output | 1 | Chip select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_standby_n | output | 1 | Converter standby, active low |
| sample_valid | output | 1 | One-cycle pulse: new word on sample_word |
| sample_word | output | DATA_W | Last captured (formatted) word |
| eoc_timeout | output | 1 | One-cycle pulse: strobe never arrived |

## Verification
Two functions can meet in one cycle. One is the standby request and the other is a start that is already due, either from the pacer or from start_req held high. Both can arrive in the first idle cycle after recovery. The bench provokes this by raising standby during a free-running conversion whose strobe comes late, so the pacer tick is overdue when the controller reaches idle. It checks that the word of that conversion is still delivered, that standby is entered, and that no further start pulse appears. A behavioural model in the bench is compared with every output pin on every clock. This checks the priority cycle by cycle, and also the wake-up lockout when a held start_req meets the end of the lockout.

// File: rtl/adc_rdctl_pkg.sv
// Package: shared state type and elaboration helpers for the ADC read controller.
// Assumes: nothing beyond IEEE 1800-2017.
package adc_rdctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT,
        ST_READ,
        ST_RECOV,
        ST_SLEEP,
        ST_WAKE
    } seq_state_e;

    // Larger of two integers, used for derived localparams.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_eoc_sync.sv
// Module: adc_eoc_sync
// Brings the asynchronous active-low end-of-conversion strobe into the clock
// domain through STAGES flops. Resets to the inactive (high) level.
// Assumes: the strobe stays low for longer than one clock period.
module adc_eoc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);

    logic [STAGES-1:0] shreg_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single flop capture.
            always_ff @(posedge clk) begin
                if (!rst_n) shreg_q <= 1'b1;
                else        shreg_q <= async_n;
            end
        end else begin : g_chain
            // Shift chain, oldest sample at the top.
            always_ff @(posedge clk) begin
                if (!rst_n) shreg_q <= '1;
                else        shreg_q <= {shreg_q[STAGES-2:0], async_n};
            end
        end
    endgenerate

    assign sync_n = shreg_q[STAGES-1];

endmodule

// File: rtl/adc_rd_pacer.sv
// Module: adc_rd_pacer
// Free-running pacer. It counts cycles since the last conversion launch and
// asks for a new start once the effective period has elapsed. The effective
// period is the programmed one, raised to MIN_PERIOD when shorter.
// Assumes: MIN_PERIOD >= 2 and fits in PER_W bits.
module adc_rd_pacer #(
    parameter int PER_W      = 16,
    parameter int MIN_PERIOD = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PER_W-1:0] period,
    input  logic             restart,
    output logic             tick
);

    localparam logic [PER_W-1:0] MIN_P_W = PER_W'(MIN_PERIOD);

    logic [PER_W-1:0] since_q;
    logic [PER_W-1:0] eff_period;

    // Cycles since last launch; saturates so the first free-run start is immediate.
    always_ff @(posedge clk) begin
        if (!rst_n)             since_q <= '1;
        else if (restart)       since_q <= '0;
        else if (since_q != '1) since_q <= since_q + 1'b1;
    end

    assign eff_period = (period < MIN_P_W) ? MIN_P_W : period;
    assign tick       = enable && (since_q >= (eff_period - 1'b1));

    // R10: the cycle after a launch can never request another start.
    a_r10_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);

endmodule

// File: rtl/adc_word_fmt.sv
// Module: adc_word_fmt
// Presents the raw converter word either unchanged or with its MSB inverted,
// which maps straight binary onto two's complement (and back).
// Assumes: W >= 2.
module adc_word_fmt #(
    parameter int W = 12
) (
    input  logic         signed_sel,
    input  logic [W-1:0] raw,
    output logic [W-1:0] word
);

    // Select presentation of the captured code.
    always_comb begin
        word = raw;
        if (signed_sel) word[W-1] = ~raw[W-1];
    end

endmodule

// File: rtl/adc_rd_seq.sv
// Module: adc_rd_seq
// Strobe sequencer: start pulse, wait for synchronized end-of-conversion (with
// timeout), chip-select/read window with capture on its last cycle, recovery,
// and standby with wake-up lockout. One down-counter times every phase.
// Assumes: all cycle counts >= 1; eoc_n_sync already synchronized.
module adc_rd_seq
    import adc_rdctl_pkg::*;
#(
    parameter int W          = 12,
    parameter int CONVST_CYC = 9,
    parameter int TMO_CYC    = 500,
    parameter int RD_LEN     = 10,
    parameter int RECOV_CYC  = 50,
    parameter int WAKE_CYC   = 7500
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic         standby_req,
    input  logic         eoc_n_sync,
    input  logic [W-1:0] data_fmt,
    output logic         launch,
    output logic         convst_n,
    output logic         cs_n,
    output logic         rd_n,
    output logic         standby_n,
    output logic         sample_valid,
    output logic [W-1:0] sample_word,
    output logic         timeout_err
);

    localparam int CNT_MAX = max2(max2(max2(CONVST_CYC, TMO_CYC), max2(RD_LEN, RECOV_CYC)), WAKE_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] L_CONVST = CNT_W'(CONVST_CYC - 1);
    localparam logic [CNT_W-1:0] L_TMO    = CNT_W'(TMO_CYC - 1);
    localparam logic [CNT_W-1:0] L_RD     = CNT_W'(RD_LEN - 1);
    localparam logic [CNT_W-1:0] L_RECOV  = CNT_W'(RECOV_CYC - 1);
    localparam logic [CNT_W-1:0] L_WAKE   = CNT_W'(WAKE_CYC - 1);

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_zero;
    logic             latch;
    logic             err_d;
    logic             valid_q, err_q;
    logic [W-1:0]     word_q;

    assign cnt_zero = (cnt_q == '0);

    // Next-state and phase timer; standby wins over a start in idle.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        latch   = 1'b0;
        err_d   = 1'b0;
        launch  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (standby_req) begin
                    state_d = ST_SLEEP;
                end else if (go) begin
                    state_d = ST_START;
                    cnt_d   = L_CONVST;
                    launch  = 1'b1;
                end
            end
            ST_START: begin
                if (cnt_zero) begin
                    state_d = ST_WAIT;
                    cnt_d   = L_TMO;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WAIT: begin
                if (!eoc_n_sync) begin
                    state_d = ST_READ;
                    cnt_d   = L_RD;
                end else if (cnt_zero) begin
                    state_d = ST_IDLE;
                    err_d   = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_READ: begin
                if (cnt_zero) begin
                    state_d = ST_RECOV;
                    cnt_d   = L_RECOV;
                    latch   = 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_RECOV: begin
                if (cnt_zero) state_d = ST_IDLE;
                else          cnt_d   = cnt_q - 1'b1;
            end
            ST_SLEEP: begin
                if (!standby_req) begin
                    state_d = ST_WAKE;
                    cnt_d   = L_WAKE;
                end
            end
            ST_WAKE: begin
                if (cnt_zero) state_d = ST_IDLE;
                else          cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, timer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            valid_q <= latch;
            err_q   <= err_d;
            if (latch) word_q <= data_fmt;
        end
    end

    assign convst_n     = (state_q != ST_START);
    assign cs_n         = (state_q != ST_READ);
    assign rd_n         = (state_q != ST_READ);
    assign standby_n    = (state_q != ST_SLEEP);
    assign sample_valid = valid_q;
    assign sample_word  = word_q;
    assign timeout_err  = err_q;

    // Cycles since the read strobe was last active (assertion support only).
    logic [CNT_W:0] rd_gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                 rd_gap_q <= '1;
        else if (state_q == ST_READ) rd_gap_q <= '0;
        else if (rd_gap_q != '1)    rd_gap_q <= rd_gap_q + 1'b1;
    end

    // R3: a read window opens only from a strobe seen low by the synchronizer.
    a_r3_read_needs_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && $past(state_q) == ST_WAIT) |-> !$past(eoc_n_sync));

    // R4: valid is a single-cycle pulse.
    a_r4_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    // R6: a new start pulse begins only after the full recovery time.
    a_r6_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && $past(state_q) != ST_START) |-> (rd_gap_q >= (CNT_W+1)'(RECOV_CYC)));

    // R7: a timeout flag only follows the wait phase.
    a_r7_err_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> ($past(state_q) == ST_WAIT && state_q == ST_IDLE));

    // R9: no start pulse straight out of standby.
    a_r9_no_start_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP) |=> (state_q != ST_START));

endmodule

// File: rtl/adc_par_rdctl.sv
// Module: adc_par_rdctl (top)
// Host-side controller for a parallel-bus successive-approximation ADC.
// Combines the strobe synchronizer, the free-run pacer, the word formatter
// and the strobe sequencer. All analogue minima are cycle-count parameters,
// rounded up to whole clock periods by the integrator.
// Assumes: all counts >= 1; MIN_PERIOD fits in PERIOD_W bits.
module adc_par_rdctl
    import adc_rdctl_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int PERIOD_W    = 16,
    parameter int SYNC_STAGES = 2,
    parameter int CONVST_CYC  = 9,
    parameter int CONV_CYC    = 400,
    parameter int EOC_TMO_CYC = 500,
    parameter int ACCESS_CYC  = 9,
    parameter int RD_CYC      = 10,
    parameter int RECOV_CYC   = 50,
    parameter int WAKE_CYC    = 7500
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_req,
    input  logic                free_run_en,
    input  logic [PERIOD_W-1:0] sample_period,
    input  logic                standby_req,
    input  logic                fmt_signed,
    input  logic                adc_eoc_n,
    input  logic [DATA_W-1:0]   adc_data,
    output logic                adc_convst_n,
    output logic                adc_cs_n,
    output logic                adc_rd_n,
    output logic                adc_standby_n,
    output logic                sample_valid,
    output logic [DATA_W-1:0]   sample_word,
    output logic                eoc_timeout
);

    localparam int RD_LEN     = max2(RD_CYC, ACCESS_CYC + 1);
    localparam int MIN_PERIOD = CONVST_CYC + CONV_CYC + RD_CYC + RECOV_CYC + 1;

    logic              eoc_sync_n;
    logic              pace_tick;
    logic              launch;
    logic [DATA_W-1:0] data_fmt;

    adc_eoc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (adc_eoc_n),
        .sync_n  (eoc_sync_n)
    );

    adc_rd_pacer #(.PER_W(PERIOD_W), .MIN_PERIOD(MIN_PERIOD)) u_pacer (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (free_run_en),
        .period  (sample_period),
        .restart (launch),
        .tick    (pace_tick)
    );

    adc_word_fmt #(.W(DATA_W)) u_fmt (
        .signed_sel (fmt_signed),
        .raw        (adc_data),
        .word       (data_fmt)
    );

    adc_rd_seq #(
        .W          (DATA_W),
        .CONVST_CYC (CONVST_CYC),
        .TMO_CYC    (EOC_TMO_CYC),
        .RD_LEN     (RD_LEN),
        .RECOV_CYC  (RECOV_CYC),
        .WAKE_CYC   (WAKE_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .go           (start_req | pace_tick),
        .standby_req  (standby_req),
        .eoc_n_sync   (eoc_sync_n),
        .data_fmt     (data_fmt),
        .launch       (launch),
        .convst_n     (adc_convst_n),
        .cs_n         (adc_cs_n),
        .rd_n         (adc_rd_n),
        .standby_n    (adc_standby_n),
        .sample_valid (sample_valid),
        .sample_word  (sample_word),
        .timeout_err  (eoc_timeout)
    );

    // R3: chip select and read move together.
    a_r3_cs_rd_paired: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n == adc_rd_n);

    // R2: start and read never overlap.
    a_r2_no_start_during_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(!adc_convst_n && !adc_rd_n));

endmodule

// File: tb/adc_par_rdctl_tb.sv
module adc_par_rdctl_tb;

    localparam int DW = 12, PW = 8;
    localparam int CONVST = 3, CONV = 20, ACC = 3, RD = 4, RECOV = 6, WAKE = 30, TMO = 40;
    localparam int RDL  = (RD > ACC) ? RD : ACC + 1;
    localparam int MINP = CONVST + CONV + RD + RECOV + 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_req = 0, free_run_en = 0, standby_req = 0, fmt_signed = 0;
    logic [PW-1:0] sample_period = '0;
    logic adc_eoc_n = 1'b1;
    logic [DW-1:0] adc_data = '0;
    logic adc_convst_n, adc_cs_n, adc_rd_n, adc_standby_n, sample_valid, eoc_timeout;
    logic [DW-1:0] sample_word;

    always #2 clk = ~clk;

    adc_par_rdctl #(.DATA_W(DW), .PERIOD_W(PW), .SYNC_STAGES(2), .CONVST_CYC(CONVST),
        .CONV_CYC(CONV), .EOC_TMO_CYC(TMO), .ACCESS_CYC(ACC), .RD_CYC(RD),
        .RECOV_CYC(RECOV), .WAKE_CYC(WAKE)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .free_run_en(free_run_en),
        .sample_period(sample_period), .standby_req(standby_req), .fmt_signed(fmt_signed),
        .adc_eoc_n(adc_eoc_n), .adc_data(adc_data), .adc_convst_n(adc_convst_n),
        .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .adc_standby_n(adc_standby_n),
        .sample_valid(sample_valid), .sample_word(sample_word), .eoc_timeout(eoc_timeout));

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    int  adc_dly = 12;
    bit  adc_live = 1;
    logic [DW-1:0] next_code = '0, cur_code = '0;
    int  tmr = 0, eoc_left = 0, rd_low = 0;
    logic cv_prev = 1'b1;
    always @(posedge clk) begin
        if (!rst_n) begin
            tmr = 0; eoc_left = 0; rd_low = 0; cv_prev = 1'b1;
            adc_eoc_n <= 1'b1; adc_data <= 12'hA5A;
        end else begin
            if (cv_prev && !adc_convst_n) begin
                if (adc_live) tmr = adc_dly;
                cur_code = next_code;
            end else if (tmr > 0) begin
                tmr--;
                if (tmr == 0) eoc_left = 4;
            end
            adc_eoc_n <= !(eoc_left > 0);
            if (eoc_left > 0) eoc_left--;
            rd_low = !adc_rd_n ? rd_low + 1 : 0;
            adc_data <= (rd_low >= ACC) ? cur_code : 12'hA5A;
            cv_prev = adc_convst_n;
        end
    end

    // ---------------- cycle reference model ----------------
    // phases: 0 idle, 1 start, 2 wait, 3 read, 4 recovery, 5 standby, 6 wake
    int m_ph = 0, m_left = 0, m_since = 255;
    bit m_valid = 0, m_err = 0;
    logic m_s1 = 1, m_s2 = 1;
    logic [DW-1:0] m_word = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_since = 255; m_valid = 0; m_err = 0;
            m_s1 = 1; m_s2 = 1; m_word = '0;
        end else begin
            logic eoc_seen;
            int eff;
            bit go, launched;
            eoc_seen = !m_s2;
            m_s2 = m_s1; m_s1 = adc_eoc_n;
            eff = (int'(sample_period) < MINP) ? MINP : int'(sample_period);
            go = start_req || (free_run_en && m_since >= eff - 1);
            launched = 0; m_valid = 0; m_err = 0;
            case (m_ph)
                0: if (standby_req) m_ph = 5;
                   else if (go) begin m_ph = 1; m_left = CONVST; launched = 1; end
                1: begin m_left--; if (m_left == 0) begin m_ph = 2; m_left = TMO; end end
                2: if (eoc_seen) begin m_ph = 3; m_left = RDL; end
                   else begin m_left--; if (m_left == 0) begin m_ph = 0; m_err = 1; end end
                3: begin
                    m_left--;
                    if (m_left == 0) begin
                        m_word = fmt_signed ? {~cur_code[DW-1], cur_code[DW-2:0]} : cur_code;
                        m_valid = 1; m_ph = 4; m_left = RECOV;
                    end
                end
                4: begin m_left--; if (m_left == 0) m_ph = 0; end
                5: if (!standby_req) begin m_ph = 6; m_left = WAKE; end
                6: begin m_left--; if (m_left == 0) m_ph = 0; end
                default: m_ph = 0;
            endcase
            if (launched) m_since = 0;
            else if (m_since < 255) m_since++;
        end
    end

    // Compare every pin with the model on every clock.
    bit cmp_on = 0;
    always @(negedge clk) if (cmp_on && !done) begin
        chk("R2 convst_n vs model", adc_convst_n, m_ph != 1);
        chk("R3 cs_n vs model", adc_cs_n, m_ph != 3);
        chk("R3 rd_n vs model", adc_rd_n, m_ph != 3);
        chk("R9 standby_n vs model", adc_standby_n, m_ph != 5);
        chk("R4 sample_valid vs model", sample_valid, m_valid);
        chk("R4 sample_word vs model", sample_word, m_word);
        chk("R7 eoc_timeout vs model", eoc_timeout, m_err);
    end

    // ---------------- measurement monitor ----------------
    int cyc = 0, falls = 0, last_fall = 0, fall_gap = 0, last_rd_rise = 0, rd_to_cv = 0;
    int last_stb_rise = 0, stb_to_cv = 0, cv_run = 0, cv_width = 0, rd_run = 0, rd_width = 0;
    int rd_falls = 0, errs = 0, valids = 0;
    logic p_cv = 1, p_rd = 1, p_stb = 1;
    always @(negedge clk) if (rst_n) begin
        cyc++;
        if (p_cv && !adc_convst_n) begin
            falls++; fall_gap = cyc - last_fall; last_fall = cyc;
            rd_to_cv = cyc - last_rd_rise; stb_to_cv = cyc - last_stb_rise;
        end
        if (!adc_convst_n) cv_run++; else if (!p_cv) begin cv_width = cv_run; cv_run = 0; end
        if (!adc_rd_n) rd_run++; else if (!p_rd) begin rd_width = rd_run; rd_run = 0; last_rd_rise = cyc; end
        if (p_rd && !adc_rd_n) rd_falls++;
        if (!p_stb && adc_standby_n) last_stb_rise = cyc;
        if (eoc_timeout) errs++;
        if (sample_valid) valids++;
        p_cv = adc_convst_n; p_rd = adc_rd_n; p_stb = adc_standby_n;
    end

    // Watchdog: a hung run is a failed check.
    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd == 150000 && !done) begin
            done = 1; n_fail++; n_tests++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic step(input int n); repeat (n) @(negedge clk); endtask
    task automatic pulse_start; start_req = 1; @(negedge clk); start_req = 0; endtask
    task automatic wait_valid(input string req, input int lim);
        bit got = 0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (sample_valid) begin got = 1; break; end
        end
        chk({req, " valid arrived"}, got, 1);
    endtask
    task automatic one_conv(input string req, input logic [DW-1:0] code, input logic f, input int exp);
        next_code = code; fmt_signed = f;
        pulse_start();
        wait_valid(req, 100);
        chk({req, " sample_word"}, sample_word, exp);
        step(RECOV + 4);
    endtask

    initial begin
        int f0, e0, r0, v0;
        // R1: reset state
        step(3);
        chk("R1 convst_n in reset", adc_convst_n, 1);
        chk("R1 cs_n in reset", adc_cs_n, 1);
        chk("R1 rd_n in reset", adc_rd_n, 1);
        chk("R1 standby_n in reset", adc_standby_n, 1);
        chk("R1 valid in reset", sample_valid, 0);
        chk("R1 timeout in reset", eoc_timeout, 0);
        chk("R1 word in reset", sample_word, 0);
        rst_n = 1; cmp_on = 1;
        step(2);

        // R2, R3, R4: one plain conversion
        one_conv("R4", 12'h123, 0, 12'h123);
        chk("R2 start pulse width", cv_width, CONVST);
        chk("R3 read window width", rd_width, RDL);

        // R5: format selection
        one_conv("R5 signed 0x800", 12'h800, 1, 12'h000);
        one_conv("R5 signed 0x7FF", 12'h7FF, 1, 12'hFFF);
        one_conv("R5 plain 0xFFF", 12'hFFF, 0, 12'hFFF);

        // R8: extra request during conversion is ignored
        f0 = falls;
        next_code = 12'h456;
        pulse_start(); step(5); pulse_start();
        wait_valid("R8", 100);
        step(RECOV + 6);
        chk("R8 one start for two requests", falls - f0, 1);
        chk("R8 word of that conversion", sample_word, 12'h456);

        // R6: back-to-back requests honour recovery
        start_req = 1;
        wait_valid("R6 first", 100);
        wait_valid("R6 second", 100);
        step(RECOV + 3);
        start_req = 0;
        chk("R6 read-rise to next start", rd_to_cv, RECOV + 1);
        step(60);

        // R7: no strobe leads to timeout
        adc_live = 0; e0 = errs; r0 = rd_falls;
        pulse_start(); step(TMO + 20);
        chk("R7 one timeout pulse", errs - e0, 1);
        chk("R7 no read after timeout", rd_falls - r0, 0);
        adc_live = 1;

        // R9: standby blocks starts and enforces wake lockout
        standby_req = 1; step(3);
        chk("R9 standby_n low", adc_standby_n, 0);
        f0 = falls; start_req = 1; step(10);
        chk("R9 no start while in standby", falls - f0, 0);
        standby_req = 0;
        wait_valid("R9 after wake", 200);
        start_req = 0;
        chk("R9 wake lockout to first start", stb_to_cv, WAKE + 1);
        step(60);

        // R10: free-running period, programmed and clamped
        free_run_en = 1; sample_period = 8'd60; next_code = 12'h321;
        step(200);
        chk("R10 programmed period", fall_gap, 60);
        sample_period = 8'd2;
        step(150);
        chk("R10 clamped period", fall_gap, MINP);

        // R11: standby raised mid-conversion, pacer overdue at idle
        adc_dly = 22;
        step(2);
        while (adc_convst_n) @(negedge clk);
        v0 = valids; f0 = falls;
        standby_req = 1;
        step(150);
        chk("R11 pending conversion delivered", valids - v0, 1);
        chk("R11 no start after standby request", falls - f0, 0);
        chk("R11 standby entered", adc_standby_n, 0);
        standby_req = 0; free_run_en = 0;
        step(80);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule